// File: doc/BRIEF.md
# Privilege-Gated Interrupt Pending Arbiter

This block holds the pending interrupt state of one processor thread. There are seven interrupt classes, and each class has a 64-bit pending vector plus one summary bit. Producers raise a bit with the post port and retire it with the clear port. Each port takes a class number and a bit index. A clear-all input, or the synchronous reset, wipes the whole state.

Two mode inputs select which classes may interrupt: a hyperprivileged flag and an interrupt-enable flag. The block reports whether an interrupt should be taken and which class wins under a fixed, mode-dependent priority. It also gives a 4-bit level derived from the software-interrupt vector. A read port returns the pending vector of any class. The trap logic uses the winner and the level, and it retires bits through the clear port.

Class numbers on every port: 1 tick match, 2 interrupt vector, 3 trap-level-zero, 4 CPU mondo, 5 device mondo, 6 software interrupt, 7 resumable error. Value 0 is reserved.

Top module: `irq_pend_arb`

## Requirements
- R1: A post with class 1..7 and index 0..63 sets that bit of that class vector at the next rising clock edge, and the class becomes pending.
- R2: A clear resets the addressed bit at the next edge. The class stays pending while any other bit of its vector is still set.
- R3: Clear-all or reset zeroes every vector and every summary bit at the next edge. Clear-all overrides a post or clear in the same cycle.
- R4: When post and clear address the same class and bit in the same cycle, the bit ends up set.
- R5: Class number 0 on the post or clear port changes nothing. Class 0 on the read port returns zero.
- R6: When no class is pending, `irq_pend` is 0 and `irq_code` is 0, in either mode.
- R7: With `hpriv`=1, only class 1, and after it class 2, can win, and only when `ie`=1. Every other class is masked.
- R8: With `hpriv`=0, the order is class 3, then 1, then 2, regardless of `ie`. When `ie`=1, classes 4, 5, 6 and 7 follow, in that order.
- R9: `sw_lvl` is 14 whenever bit 16 or bit 0 of the class-6 vector is set.
- R10: Otherwise `sw_lvl` is the index of the highest set bit among bits 15..1 of the class-6 vector, or 0 if none is set.
- R11: `irq_pend`, `irq_code` and `sw_lvl` are combinational from the stored state and the mode inputs. A mode change shows in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post request |
| post_cls | input | 3 | Class to post into (1..7) |
| post_idx | input | 6 | Bit index to post |
| clr_en | input | 1 | Clear request |
| clr_cls | input | 3 | Class to clear in (1..7) |
| clr_idx | input | 6 | Bit index to clear |
| clr_all | input | 1 | Wipe all vectors and summaries |
| hpriv | input | 1 | Hyperprivileged mode |
| ie | input | 1 | Interrupt enable |
| rd_cls | input | 3 | Class whose vector is read |
| rd_vec | output | 64 | Pending vector of `rd_cls` |
| irq_pend | output | 1 | An interrupt should be taken |
| irq_code | output | 3 | Winning class, 0 when none |
| sw_lvl | output | 4 | Software-interrupt level |

## Verification
A post, clear or clear-all changes the state one edge after it is driven. The bench therefore updates its behavioural model just after each rising edge and compares every output, including a read of all eight class numbers, a short time after that edge. Mode changes act with no clock. So each new drive is also followed, before the next edge, by a check of the arbitration outputs against the old state and the new mode.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int VEC_W     = 64;
    localparam int NUM_CLS   = 7;
    localparam int CLS_W     = 3;
    localparam int IDX_W     = $clog2(VEC_W);
    localparam int LVL_W     = 4;
    localparam int SOFT_SPAN = 17;   // bits 16..0 feed the level encoder
    localparam int SOFT_HI   = 15;   // highest bit searched for a level
    localparam int SOFT_FORCE_LVL = 14;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 3'd0,
        CLS_HTICK  = 3'd1,
        CLS_IVEC   = 3'd2,
        CLS_TLZ    = 3'd3,
        CLS_CMONDO = 3'd4,
        CLS_DMONDO = 3'd5,
        CLS_SOFT   = 3'd6,
        CLS_RESERR = 3'd7
    } irq_cls_e;

    typedef struct packed {
        logic             en;
        logic [CLS_W-1:0] cls;
        logic [IDX_W-1:0] idx;
    } irq_op_s;

    function automatic logic cls_ok(input logic [CLS_W-1:0] c);
        return (c != '0) && (int'(c) <= NUM_CLS);
    endfunction

    function automatic int slot(input irq_cls_e c);
        return int'(c) - 1;
    endfunction
endpackage

// File: rtl/irq_class_store.sv
module irq_class_store
    import irq_arb_pkg::*;
#(
    parameter int NUM = NUM_CLS,
    parameter int VW  = VEC_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr_all,
    input  irq_op_s                post_op,
    input  irq_op_s                clr_op,
    output logic [NUM-1:0][VW-1:0] vec_q,
    output logic [NUM-1:0]         sum_q
);
    for (genvar c = 0; c < NUM; c++) begin : g_cls
        localparam logic [CLS_W-1:0] ID = CLS_W'(c + 1);
        logic [VW-1:0] set_m, clr_m, nxt, v_q;
        logic          s_q;

        always_comb begin
            set_m = '0;
            clr_m = '0;
            if (post_op.en && post_op.cls == ID) set_m[post_op.idx] = 1'b1;
            if (clr_op.en  && clr_op.cls  == ID) clr_m[clr_op.idx]  = 1'b1;
            // set is applied after clear so a colliding post wins
            nxt = (v_q & ~clr_m) | set_m;
        end

        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                v_q <= '0;
                s_q <= 1'b0;
            end else begin
                v_q <= nxt;
                s_q <= |nxt;
            end
        end

        assign vec_q[c] = v_q;
        assign sum_q[c] = s_q;
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_arb_pkg::*;
#(
    parameter int NUM = NUM_CLS
) (
    input  logic [NUM-1:0] sum_i,
    input  logic           hpriv,
    input  logic           ie,
    output logic           win_vld,
    output irq_cls_e       win_cls
);
    logic has_tick, has_ivec, has_tlz, has_cm, has_dm, has_soft, has_res;

    assign has_tick = sum_i[slot(CLS_HTICK)];
    assign has_ivec = sum_i[slot(CLS_IVEC)];
    assign has_tlz  = sum_i[slot(CLS_TLZ)];
    assign has_cm   = sum_i[slot(CLS_CMONDO)];
    assign has_dm   = sum_i[slot(CLS_DMONDO)];
    assign has_soft = sum_i[slot(CLS_SOFT)];
    assign has_res  = sum_i[slot(CLS_RESERR)];

    always_comb begin
        win_cls = CLS_NONE;
        if (hpriv) begin
            if (ie) begin
                if (has_tick)      win_cls = CLS_HTICK;
                else if (has_ivec) win_cls = CLS_IVEC;
            end
        end else begin
            if (has_tlz)       win_cls = CLS_TLZ;
            else if (has_tick) win_cls = CLS_HTICK;
            else if (has_ivec) win_cls = CLS_IVEC;
            else if (ie) begin
                if (has_cm)        win_cls = CLS_CMONDO;
                else if (has_dm)   win_cls = CLS_DMONDO;
                else if (has_soft) win_cls = CLS_SOFT;
                else if (has_res)  win_cls = CLS_RESERR;
            end
        end
        win_vld = (win_cls != CLS_NONE);
    end
endmodule

// File: rtl/irq_swlvl_enc.sv
module irq_swlvl_enc
    import irq_arb_pkg::*;
#(
    parameter int SPAN = SOFT_SPAN,
    parameter int LW   = LVL_W
) (
    input  logic [SPAN-1:0] soft_i,
    output logic [LW-1:0]   lvl_o
);
    localparam int FORCE_HI = SPAN - 1;

    always_comb begin
        lvl_o = '0;
        for (int i = 1; i <= SOFT_HI; i++) begin
            if (soft_i[i]) lvl_o = LW'(i);
        end
        if (soft_i[FORCE_HI] || soft_i[0]) lvl_o = LW'(SOFT_FORCE_LVL);
    end
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              post_en,
    input  logic [CLS_W-1:0]  post_cls,
    input  logic [IDX_W-1:0]  post_idx,
    input  logic              clr_en,
    input  logic [CLS_W-1:0]  clr_cls,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              clr_all,
    input  logic              hpriv,
    input  logic              ie,
    input  logic [CLS_W-1:0]  rd_cls,
    output logic [VEC_W-1:0]  rd_vec,
    output logic              irq_pend,
    output logic [CLS_W-1:0]  irq_code,
    output logic [LVL_W-1:0]  sw_lvl
);
    irq_op_s                       post_op, clr_op;
    logic [NUM_CLS-1:0][VEC_W-1:0] vec_q;
    logic [NUM_CLS-1:0]            sum_q;
    irq_cls_e                      win_cls;
    logic                          win_vld;

    assign post_op = '{en: post_en && cls_ok(post_cls), cls: post_cls, idx: post_idx};
    assign clr_op  = '{en: clr_en  && cls_ok(clr_cls),  cls: clr_cls,  idx: clr_idx};

    irq_class_store #(.NUM(NUM_CLS), .VW(VEC_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .post_op (post_op),
        .clr_op  (clr_op),
        .vec_q   (vec_q),
        .sum_q   (sum_q)
    );

    irq_prio_sel #(.NUM(NUM_CLS)) u_prio (
        .sum_i   (sum_q),
        .hpriv   (hpriv),
        .ie      (ie),
        .win_vld (win_vld),
        .win_cls (win_cls)
    );

    irq_swlvl_enc #(.SPAN(SOFT_SPAN), .LW(LVL_W)) u_lvl (
        .soft_i (vec_q[slot(CLS_SOFT)][SOFT_SPAN-1:0]),
        .lvl_o  (sw_lvl)
    );

    always_comb begin
        rd_vec = '0;
        if (cls_ok(rd_cls)) rd_vec = vec_q[rd_cls - CLS_W'(1)];
    end

    assign irq_pend = win_vld;
    assign irq_code = win_cls;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
    import irq_arb_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       post_en,
    input logic [CLS_W-1:0]           post_cls,
    input logic [IDX_W-1:0]           post_idx,
    input logic                       clr_en,
    input logic [CLS_W-1:0]           clr_cls,
    input logic [IDX_W-1:0]           clr_idx,
    input logic                       clr_all,
    input logic                       hpriv,
    input logic                       ie,
    input logic                       irq_pend,
    input logic [CLS_W-1:0]           irq_code,
    input logic [LVL_W-1:0]           sw_lvl,
    input logic [NUM_CLS*VEC_W-1:0]   vecs
);
    localparam int BIT_W = CLS_W + IDX_W;

    logic             post_chk_q, clr_chk_q, both_q;
    logic [BIT_W-1:0] post_bit_q, clr_bit_q;
    logic             same_bit;

    assign same_bit = post_en && clr_en && post_cls == clr_cls && post_idx == clr_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            post_chk_q <= 1'b0;
            clr_chk_q  <= 1'b0;
            both_q     <= 1'b0;
            post_bit_q <= '0;
            clr_bit_q  <= '0;
        end else begin
            post_chk_q <= post_en && cls_ok(post_cls) && !clr_all;
            clr_chk_q  <= clr_en && cls_ok(clr_cls) && !clr_all && !same_bit;
            both_q     <= same_bit && cls_ok(post_cls) && !clr_all;
            post_bit_q <= {post_cls - CLS_W'(1), post_idx};
            clr_bit_q  <= {clr_cls - CLS_W'(1), clr_idx};
        end
    end

    a_r1_post_sets: assert property (@(posedge clk) disable iff (rst)
        post_chk_q |-> vecs[post_bit_q]);

    a_r2_clear_resets: assert property (@(posedge clk) disable iff (rst)
        clr_chk_q |-> !vecs[clr_bit_q]);

    a_r3_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (vecs == '0));

    a_r4_post_wins: assert property (@(posedge clk) disable iff (rst)
        both_q |-> vecs[post_bit_q]);

    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        (vecs == '0) |-> (!irq_pend && irq_code == '0));

    a_r7_hpriv_gate: assert property (@(posedge clk) disable iff (rst)
        (hpriv && irq_pend) |-> (ie && (irq_code == CLS_HTICK || irq_code == CLS_IVEC)));

    a_r8_tlz_first: assert property (@(posedge clk) disable iff (rst)
        (!hpriv && vecs[slot(CLS_TLZ)*VEC_W +: VEC_W] != '0) |-> (irq_pend && irq_code == CLS_TLZ));

    a_r9_force14: assert property (@(posedge clk) disable iff (rst)
        (vecs[slot(CLS_SOFT)*VEC_W] || vecs[slot(CLS_SOFT)*VEC_W + 16]) |-> (sw_lvl == LVL_W'(14)));
endmodule

bind irq_pend_arb irq_arb_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .post_en  (post_en),
    .post_cls (post_cls),
    .post_idx (post_idx),
    .clr_en   (clr_en),
    .clr_cls  (clr_cls),
    .clr_idx  (clr_idx),
    .clr_all  (clr_all),
    .hpriv    (hpriv),
    .ie       (ie),
    .irq_pend (irq_pend),
    .irq_code (irq_code),
    .sw_lvl   (sw_lvl),
    .vecs     (vec_q)
);

// File: tb/tb_irq_pend_arb.sv
module tb_irq_pend_arb;
    localparam int CLK_PERIOD = 40;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int WATCHDOG   = 2000 * CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst, post_en, clr_en, clr_all, hpriv, ie;
    logic [2:0]  post_cls, clr_cls, rd_cls;
    logic [5:0]  post_idx, clr_idx;
    logic [63:0] rd_vec;
    logic        irq_pend;
    logic [2:0]  irq_code;
    logic [3:0]  sw_lvl;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [63:0] mv [0:7];   // index 0 unused; classes 1..7

    always #(HALF) clk = ~clk;

    irq_pend_arb dut (
        .clk(clk), .rst(rst),
        .post_en(post_en), .post_cls(post_cls), .post_idx(post_idx),
        .clr_en(clr_en), .clr_cls(clr_cls), .clr_idx(clr_idx),
        .clr_all(clr_all), .hpriv(hpriv), .ie(ie),
        .rd_cls(rd_cls), .rd_vec(rd_vec),
        .irq_pend(irq_pend), .irq_code(irq_code), .sw_lvl(sw_lvl)
    );

    function automatic int exp_code();
        if (hpriv) begin
            if (ie) begin
                if (mv[1] != 0) return 1;
                if (mv[2] != 0) return 2;
            end
            return 0;
        end
        if (mv[3] != 0) return 3;
        if (mv[1] != 0) return 1;
        if (mv[2] != 0) return 2;
        if (ie) begin
            for (int k = 4; k <= 7; k++) if (mv[k] != 0) return k;
        end
        return 0;
    endfunction

    function automatic int exp_lvl();
        if (mv[6][16] || mv[6][0]) return 14;
        for (int k = 15; k >= 1; k--) if (mv[6][k]) return k;
        return 0;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string tag);
        int ec;
        ec = exp_code();
        check(tag, "irq_pend", longint'(irq_pend), longint'(ec != 0));
        check(tag, "irq_code", longint'(irq_code), longint'(ec));
        check(tag, "sw_lvl",   longint'(sw_lvl),   longint'(exp_lvl()));
    endtask

    task automatic chk_rd(input string tag);
        for (int c = 0; c < 8; c++) begin
            rd_cls = 3'(c);
            #1;
            check(tag, $sformatf("rd_vec[%0d]", c), longint'(rd_vec), longint'(c == 0 ? 64'd0 : mv[c]));
        end
    endtask

    task automatic model_edge();
        if (rst || clr_all) begin
            for (int c = 0; c < 8; c++) mv[c] = '0;
        end else begin
            if (clr_en && clr_cls != 0) mv[clr_cls][clr_idx] = 1'b0;
            if (post_en && post_cls != 0) mv[post_cls][post_idx] = 1'b1;
        end
    endtask

    // called at a falling edge with the inputs already driven
    task automatic cyc(input string tag);
        #1;
        chk_out({tag, "/R11"});
        @(posedge clk);
        model_edge();
        #1;
        chk_out(tag);
        chk_rd(tag);
        @(negedge clk);
        post_en = 0; clr_en = 0; clr_all = 0; rst = 0;
    endtask

    task automatic do_post(input int c, input int i, input string tag);
        post_en = 1; post_cls = 3'(c); post_idx = 6'(i);
        cyc(tag);
    endtask

    task automatic do_clr(input int c, input int i, input string tag);
        clr_en = 1; clr_cls = 3'(c); clr_idx = 6'(i);
        cyc(tag);
    endtask

    task automatic mode(input bit h, input bit e, input string tag);
        hpriv = h; ie = e;
        cyc(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(WATCHDOG);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 8; c++) mv[c] = '0;
        rst = 1; post_en = 0; clr_en = 0; clr_all = 0; hpriv = 0; ie = 1;
        post_cls = 0; post_idx = 0; clr_cls = 0; clr_idx = 0; rd_cls = 0;
        @(negedge clk);
        rst = 1;
        cyc("R3 reset");
        rst = 0;

        // R8: fill from lowest priority upward, non-hyperprivileged, ie=1
        do_post(7, 3,  "R1 R8 reserr");
        do_post(6, 40, "R1 R8 R10 soft no level bit");
        do_post(5, 9,  "R1 R8 dmondo");
        do_post(4, 63, "R1 R8 cmondo");
        do_post(2, 1,  "R1 R8 ivec");
        do_post(1, 0,  "R1 R8 tick");
        do_post(3, 5,  "R1 R8 tlz");
        mode(0, 0, "R8 tlz ignores ie");
        do_clr(3, 5, "R2 R8 tick after tlz");
        // R7: hyperprivileged gating
        mode(1, 0, "R7 masked without ie");
        mode(1, 1, "R7 tick");
        do_clr(1, 0, "R2 R7 ivec");
        do_clr(2, 1, "R2 R7 lower classes masked");
        mode(0, 1, "R8 cmondo");
        do_clr(4, 63, "R2 R8 dmondo");
        do_clr(5, 9,  "R2 R8 soft");
        do_clr(6, 40, "R2 R8 reserr");

        // R9 / R10: software level encoding
        do_post(6, 7,  "R10 level 7");
        do_post(6, 15, "R10 level 15");
        do_post(6, 16, "R9 bit16 forces 14");
        do_clr(6, 16,  "R10 back to 15");
        do_post(6, 0,  "R9 bit0 forces 14");
        do_clr(6, 0,   "R10 back to 15 again");
        do_clr(6, 15,  "R10 level 7 again");
        do_post(6, 1,  "R10 level stays 7");
        do_clr(6, 7,   "R10 level 1");

        // R2: class stays pending while another bit remains
        do_post(7, 20, "R2 second bit");
        do_clr(7, 3,   "R2 still pending");
        do_clr(7, 20,  "R2 now empty");
        do_clr(6, 1,   "R6 nothing pending");
        mode(1, 1,     "R6 quiet in hpriv");
        mode(0, 1,     "R6 quiet");

        // R4: same-bit collision, post wins
        post_en = 1; post_cls = 4; post_idx = 12;
        clr_en  = 1; clr_cls  = 4; clr_idx  = 12;
        cyc("R4 post wins");
        // clear of another bit alongside a post works independently
        post_en = 1; post_cls = 4; post_idx = 13;
        clr_en  = 1; clr_cls  = 4; clr_idx  = 12;
        cyc("R2 R4 distinct bits");

        // R5: class 0 ignored
        do_post(0, 22, "R5 post class 0");
        do_clr(0, 13,  "R5 clear class 0");

        // R3: clear-all overrides same-cycle post
        do_post(2, 33, "R1 before wipe");
        clr_all = 1; post_en = 1; post_cls = 5; post_idx = 2;
        cyc("R3 clear-all over post");

        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            post_en  = ($urandom % 3) != 0;
            post_cls = 3'($urandom % 8);
            post_idx = 6'($urandom % 20);
            clr_en   = ($urandom % 2) != 0;
            clr_cls  = 3'($urandom % 8);
            clr_idx  = 6'($urandom % 20);
            clr_all  = ($urandom % 40) == 0;
            hpriv    = ($urandom % 3) == 0;
            ie       = ($urandom % 4) != 0;
            cyc("R1 R2 R7 R8 R10 mixed");
        end

        finish_run();
    end
endmodule